// File: doc/BRIEF.md
# Per-Bin Integrating Accumulator

This block keeps one running sum per frequency bin in an on-chip dual-port RAM and adds a new sample to it on every clock. An outside sequencer scans the bins. It presents a read address together with that bin's sample, its pre-shift amount and the blank and store controls. It then presents the matching write address and write enable exactly five cycles later. Over one pass the block reads the old sum, scales the sample down by a right shift, optionally zeroes the sample, optionally ignores the old sum, adds the two, clamps the result, and writes it back to the same bin.

A parameter selects the number format. In the unsigned variant, samples and sums are plain binary. In the signed variant, samples are two's complement and are sign-extended to the accumulator width. The shift is arithmetic, and clamping works toward both extremes. The word read from memory is registered and driven out, so the results of a finished integration can be unloaded while the next one is being built. A per-item saturation flag marks every sum that had to be clamped.

Top module: `spec_bin_acc`

## Requirements
- R1: The sample is widened to ACC_W bits and then shifted right by `shift` (0 to 15) before the add. The shift is logical in the unsigned variant. In the signed variant the sample is sign-extended and the shift is arithmetic.
- R2: With `blank` high, the sample term of that item is zero, so the stored sum is rewritten unchanged (or as zero if `store` is also high).
- R3: With `store` high, the old sum term of that item is zero, so the written value is the shifted, blanked sample alone.
- R4: The RAM is written only in a cycle with `wr_en` high, at `wr_addr`. The data written is the result of the item presented five cycles earlier. With `wr_en` low, stored sums are not changed.
- R5: `acc_out` shows, one cycle after a read address is presented, the RAM word at that address as it was before any write at the same clock edge.
- R6: In the unsigned variant, a sum above 2^ACC_W-1 is clamped to 2^ACC_W-1.
- R7: In the signed variant, a sum above 2^(ACC_W-1)-1 is clamped to that value, and a sum below -2^(ACC_W-1) is clamped to -2^(ACC_W-1). A sum exactly at an extreme is not clamped.
- R8: `sat_out` is high in the cycle in which a clamped item's result is on the write side (five cycles after the item was presented), and low for items that were not clamped.
- R9: A synchronous reset clears `acc_out`, `sat_out` and all pipeline stages, and leaves the RAM contents unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sample | input | IN_W | New sample for the bin at `rd_addr` |
| shift | input | SH_W | Right-shift amount applied to `sample` |
| blank | input | 1 | Zero this item's sample term |
| store | input | 1 | Zero this item's old sum term |
| rd_addr | input | ADDR_W | Bin being read this cycle |
| wr_addr | input | ADDR_W | Bin being written this cycle (read address delayed by five) |
| wr_en | input | 1 | RAM write enable |
| acc_out | output | ACC_W | Registered RAM readback |
| sat_out | output | 1 | Item on the write side was clamped |

## Verification
Both variants receive the same bit patterns, so one stimulus tells logical from arithmetic shifting (0xF0 shifted by up to 15) and shows clamping in one number format but not in the other. The frames used are: a store frame of distinct per-bin values, an accumulate frame with a different shift per bin, a blank frame, and a frame with writes disabled. Each of these changes only one term of the sum, and the readback frame that follows shows which term was dropped. Repeated 0xFF frames drive the unsigned sums into the top clamp. Alternating 0x7F/0x80 frames drive the signed sums into both extremes, and one frame lands exactly on the negative limit, which separates an off-by-one clamp from a correct one. A reset in mid-run followed by a read-only frame shows that the sums survive reset.

// File: rtl/spec_bin_acc.sv
module spec_bin_acc #(
  parameter int IN_W        = 16,
  parameter int ACC_W       = 32,
  parameter int ADDR_W      = 12,
  parameter int SH_W        = 4,
  parameter bit SIGNED_MODE = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IN_W-1:0]   sample,
  input  logic [SH_W-1:0]   shift,
  input  logic              blank,
  input  logic              store,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_en,
  output logic [ACC_W-1:0]  acc_out,
  output logic              sat_out
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [ACC_W-1:0] ram [DEPTH];

  logic [ACC_W-1:0] sh_smp, clamp;
  logic             ovf;
  logic [ACC_W:0]   wide;

  logic [ACC_W-1:0] rd_q, s1_smp, s2_smp, s2_rb, s3_sum, s4_sum, s5_sum;
  logic             s1_blank, s1_store, s3_sat, s4_sat;

  if (SIGNED_MODE) begin : g_sgn
    logic signed [ACC_W-1:0] ext;
    assign ext    = ACC_W'($signed(sample));
    assign sh_smp = ext >>> shift;
    assign wide   = {s2_rb[ACC_W-1], s2_rb} + {s2_smp[ACC_W-1], s2_smp};
    assign ovf    = wide[ACC_W] ^ wide[ACC_W-1];
    assign clamp  = wide[ACC_W] ? {1'b1, {(ACC_W-1){1'b0}}} : {1'b0, {(ACC_W-1){1'b1}}};

    // R7: a clamped signed word sits at one of the two extremes
    p_signed_clamp_r7: assert property (@(posedge clk) disable iff (rst)
      sat_out |-> (s5_sum == {1'b1, {(ACC_W-1){1'b0}}} || s5_sum == {1'b0, {(ACC_W-1){1'b1}}}));
  end else begin : g_uns
    assign sh_smp = ACC_W'(sample) >> shift;
    assign wide   = {1'b0, s2_rb} + {1'b0, s2_smp};
    assign ovf    = wide[ACC_W];
    assign clamp  = '1;

    // R6: a clamped unsigned word is all ones
    p_unsigned_clamp_r6: assert property (@(posedge clk) disable iff (rst)
      sat_out |-> s5_sum == '1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q     <= '0;
      s1_smp   <= '0;
      s1_blank <= 1'b0;
      s1_store <= 1'b0;
      s2_smp   <= '0;
      s2_rb    <= '0;
      s3_sum   <= '0;
      s3_sat   <= 1'b0;
      s4_sum   <= '0;
      s4_sat   <= 1'b0;
      s5_sum   <= '0;
      sat_out  <= 1'b0;
    end else begin
      rd_q     <= ram[rd_addr];
      s1_smp   <= sh_smp;
      s1_blank <= blank;
      s1_store <= store;
      s2_smp   <= s1_blank ? '0 : s1_smp;
      s2_rb    <= s1_store ? '0 : rd_q;
      s3_sum   <= ovf ? clamp : wide[ACC_W-1:0];
      s3_sat   <= ovf;
      s4_sum   <= s3_sum;
      s4_sat   <= s3_sat;
      s5_sum   <= s4_sum;
      sat_out  <= s4_sat;
    end
  end

  always_ff @(posedge clk)
    if (wr_en) ram[wr_addr] <= s5_sum;

  assign acc_out = rd_q;

  // R2: a blanked item that is also a store produces a zero sum
  p_blank_store_r2: assert property (@(posedge clk) disable iff (rst)
    (s1_blank && s1_store) |=> ##1 (s3_sum == '0 && !s3_sat));

  // R9: the cycle after reset shows cleared outputs
  p_reset_clear_r9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (acc_out == '0 && !sat_out));

endmodule

// File: tb/test_spec_bin_acc.sv
module test_spec_bin_acc;
  localparam int IW = 8, AW = 10, DW = 12, NB = 8, BASE = 100;
  localparam int UMAX = (1 << AW) - 1, SMAX = (1 << (AW-1)) - 1, SMIN = -(1 << (AW-1));

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst = 1'b1, blank = 1'b0, store = 1'b0, wr_en = 1'b0;
  logic [IW-1:0] sample = '0;
  logic [3:0]    shift = '0;
  logic [DW-1:0] rd_addr = '0, wr_addr = '0;
  logic [AW-1:0] acc_u, acc_s;
  logic          sat_u, sat_s;

  spec_bin_acc #(.IN_W(IW), .ACC_W(AW), .ADDR_W(DW), .SH_W(4), .SIGNED_MODE(1'b0)) i_spec_bin_acc (
    .clk(clk), .rst(rst), .sample(sample), .shift(shift), .blank(blank), .store(store),
    .rd_addr(rd_addr), .wr_addr(wr_addr), .wr_en(wr_en), .acc_out(acc_u), .sat_out(sat_u));

  spec_bin_acc #(.IN_W(IW), .ACC_W(AW), .ADDR_W(DW), .SH_W(4), .SIGNED_MODE(1'b1)) i_spec_bin_acc_sgn (
    .clk(clk), .rst(rst), .sample(sample), .shift(shift), .blank(blank), .store(store),
    .rd_addr(rd_addr), .wr_addr(wr_addr), .wr_en(wr_en), .acc_out(acc_s), .sat_out(sat_s));

  typedef struct { int val; bit sat; } item_t;

  int    mem_m [2][4096];
  bit    mval [4096];
  item_t q_m [2][$];
  int    h_addr [$];
  bit    h_we [$];
  int    exp_acc [2];
  bit    exp_sat [2];
  bit    exp_ok = 1'b0;
  int    checks = 0, fails = 0;
  string tag = "R9";
  bit    done = 1'b0;

  function automatic void model_item(input bit sgn, input int rb_bits, input logic [IW-1:0] smp,
                                     input int sh, input bit bl, input bit st,
                                     output int res, output bit sat);
    int s, rb, sum, mx, mn;
    if (sgn) begin
      s  = int'($signed(smp)) >>> sh;
      rb = (rb_bits > SMAX) ? rb_bits - (1 << AW) : rb_bits;
      mx = SMAX; mn = SMIN;
    end else begin
      s  = int'(smp) >> sh;
      rb = rb_bits;
      mx = UMAX; mn = 0;
    end
    if (bl) s = 0;
    if (st) rb = 0;
    sum = s + rb;
    sat = 1'b0;
    if (sum > mx) begin sum = mx; sat = 1'b1; end
    else if (sum < mn) begin sum = mn; sat = 1'b1; end
    res = sum & UMAX;
  endfunction

  task automatic check_one(input string what, input int got, input int expv);
    checks++;
    if (got != expv) begin
      fails++;
      $display("FAIL %s %s got %0d expected %0d", tag, what, got, expv);
    end
  endtask

  task automatic check_all();
    if (exp_ok) begin
      check_one("unsigned acc_out", int'(acc_u), exp_acc[0]);
      check_one("signed acc_out",   int'(acc_s), exp_acc[1]);
    end
    check_one("unsigned sat_out", int'(sat_u), int'(exp_sat[0]));
    check_one("signed sat_out",   int'(sat_s), int'(exp_sat[1]));
  endtask

  task automatic cyc(input logic [IW-1:0] smp, input int sh, input bit bl, input bit st,
                     input int ra, input bit we, input bit r);
    int    rv [2];
    bit    ok;
    item_t it, fr;
    @(negedge clk);
    check_all();
    sample = smp; shift = sh[3:0]; blank = bl; store = st; rd_addr = ra[DW-1:0]; rst = r;
    wr_addr = h_addr.pop_front()[DW-1:0];
    wr_en   = h_we.pop_front();
    h_addr.push_back(ra);
    h_we.push_back(we);
    @(posedge clk);
    ok = mval[ra];
    for (int m = 0; m < 2; m++) rv[m] = mem_m[m][ra];
    for (int m = 0; m < 2; m++) begin
      model_item(m == 1, rv[m], smp, sh, bl, st, it.val, it.sat);
      fr = q_m[m].pop_front();
      if (wr_en) begin
        mem_m[m][wr_addr] = fr.val;
        mval[wr_addr] = 1'b1;
      end
      if (r) begin
        q_m[m].delete();
        for (int k = 0; k < 5; k++) q_m[m].push_back('{0, 1'b0});
        exp_acc[m] = 0;
      end else begin
        q_m[m].push_back(it);
        exp_acc[m] = rv[m];
      end
      exp_sat[m] = q_m[m][0].sat;
    end
    exp_ok = r || ok;
  endtask

  function automatic logic [IW-1:0] pat_val(input int pat, input int i);
    case (pat)
      0: pat_val = IW'(i * 10 + 5);
      1: pat_val = IW'(8'hF0 - i * 3);
      2: pat_val = 8'hFF;
      default: pat_val = (i % 2 == 0) ? 8'h7F : 8'h80;
    endcase
  endfunction

  task automatic frame(input string t, input int pat, input bit varsh, input bit bl,
                       input bit st, input bit we);
    tag = t;
    for (int i = 0; i < NB; i++)
      cyc(pat_val(pat, i), varsh ? ((i == NB-1) ? 15 : i * 2) : 0, bl, st, BASE + i, we, 1'b0);
  endtask

  task automatic idle(input int n, input bit r);
    for (int i = 0; i < n; i++) cyc('0, 0, 1'b1, 1'b0, BASE, 1'b0, r);
  endtask

  initial begin
    for (int k = 0; k < 5; k++) begin
      h_addr.push_back(0); h_we.push_back(1'b0);
      q_m[0].push_back('{0, 1'b0}); q_m[1].push_back('{0, 1'b0});
    end
    exp_sat[0] = 1'b0; exp_sat[1] = 1'b0;
    tag = "R9 reset state";
    cyc('0, 0, 1'b0, 1'b0, 0, 1'b0, 1'b1);
    exp_ok = 1'b1;
    idle(3, 1'b1);
    frame("R3 store frame",               0, 1'b0, 1'b0, 1'b1, 1'b1);
    frame("R1 shifted accumulate",        1, 1'b1, 1'b0, 1'b0, 1'b1);
    frame("R2 blank frame",               0, 1'b0, 1'b1, 1'b0, 1'b1);
    frame("R4 writes disabled",           2, 1'b0, 1'b0, 1'b0, 1'b0);
    frame("R5 readback",                  0, 1'b0, 1'b1, 1'b0, 1'b0);
    frame("R2 blank with store",          2, 1'b0, 1'b1, 1'b1, 1'b1);
    frame("R7 R8 signed store",           3, 1'b0, 1'b0, 1'b1, 1'b1);
    for (int f = 0; f < 5; f++)
      frame("R7 R8 signed clamp",         3, 1'b0, 1'b0, 1'b0, 1'b1);
    frame("R6 R8 unsigned store",         2, 1'b0, 1'b0, 1'b1, 1'b1);
    for (int f = 0; f < 5; f++)
      frame("R6 R8 unsigned clamp",       2, 1'b0, 1'b0, 1'b0, 1'b1);
    frame("R5 readback",                  0, 1'b0, 1'b1, 1'b0, 1'b0);
    tag = "R9 mid reset";
    idle(6, 1'b0);
    idle(3, 1'b1);
    frame("R9 contents kept",             0, 1'b0, 1'b1, 1'b0, 1'b0);
    tag = "R5 drain";
    idle(8, 1'b0);
    @(negedge clk);
    check_all();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL %s watchdog expired got hang expected completion", tag);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule